// File: doc/BRIEF.md
# Quadrature Position Counter with Index Modes

This block keeps a 32-bit position count from an incremental encoder. The A and B channels are synchronised and decoded at four counts per cycle. The count rises when A leads B and falls when B leads A. The same counter can also follow an external clock, with the direction taken from a pin or from a gate, or it can run as a timer on a prescaled internal clock.

In the two encoder-driven modes, an index pulse is accepted only while the conditioned A/B pair equals a programmable match pattern. A 3-bit initialisation mode decides what an accepted index does. It can do nothing, clear the count, load a preset once, or load the preset on the first or second index after a home pulse. Two further settings do not use the index at all: one clears the count when it reaches a compare value, and one wraps the count between a lower and an upper bound. A last setting combines the wrap with a reload from the lower bound on every index. Software can overwrite the count at any time, and a module enable freezes it.

Top module: `qpos_counter`

## Requirements
- R1: After reset `count` is 0 and `dir_up` is 1.
- R2: In control mode 2'b00 each single-channel change of the synchronised A/B pair steps the count. Stepping through (A,B) = 00,10,11,01 counts up, and the reverse order counts down. A change of both channels at once leaves the count unchanged.
- R3: With `dir_neg` set, the quadrature direction is inverted, and in modes 2'b10 and 2'b11 the count runs down instead of up. In mode 2'b01 the direction comes from `pin_updn` alone (1 = up).
- R4: Mode 2'b10 counts rising edges of `pin_a` only while `pin_gate` is high, and ignores index events whatever `init_mode` holds.
- R5: Mode 2'b11 counts one step every 2^`prescale_sel` clocks while enabled. The first step comes 2^`prescale_sel` clocks after counting is enabled.
- R6: With `gate_en` set and `pin_gate` low, the count does not step.
- R7: With `enable` low the count holds. A `cnt_wr` cycle loads `cnt_wdata` whether or not the block is enabled.
- R8: An index event is a rising edge of `pin_index` seen while {B,A}, taken after the optional swap (`swap_ab`) and the optional inversion of both channels (`invert_ab`), equals `match_ab` (bit 1 for B, bit 0 for A). In `init_mode` 3'b001 every index event clears the count.
- R9: In `init_mode` 3'b010 the next index event loads `init_val`, and later index events do nothing until an `arm_next` pulse. The block leaves reset armed.
- R10: In `init_mode` 3'b011 the first index event after a `pin_home` rising edge loads `init_val`. In 3'b100 the second such event does. No load happens without a fresh home edge.
- R11: In `init_mode` 3'b101 the count returns to 0 on the clock after it equals `cmp_val`.
- R12: In `init_mode` 3'b110 and 3'b111 the count wraps on counting up from `cmp_val` to `load_val`, and on counting down from `load_val` to `cmp_val`.
- R13: In `init_mode` 3'b111 every index event loads `load_val`.
- R14: `dir_up` shows the direction of the most recent count step.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| enable | input | 1 | Counting enable |
| ctl_mode | input | 2 | 00 quadrature, 01 ext clock + up/down pin, 10 ext clock gated, 11 internal timer |
| init_mode | input | 3 | Index/initialisation behaviour select |
| dir_neg | input | 1 | Invert counting direction |
| gate_en | input | 1 | Let `pin_gate` stall counting |
| swap_ab | input | 1 | Exchange A and B |
| invert_ab | input | 1 | Invert A and B |
| match_ab | input | 2 | {B,A} pattern qualifying index |
| prescale_sel | input | 3 | Timer divide by 2^n |
| arm_next | input | 1 | Re-arm single-shot index load |
| cnt_wr | input | 1 | Software count write strobe |
| cnt_wdata | input | 32 | Software write value |
| init_val | input | 32 | Preset for index loads |
| cmp_val | input | 32 | Compare value / upper wrap bound |
| load_val | input | 32 | Lower wrap bound / index reload value |
| pin_a | input | 1 | Channel A |
| pin_b | input | 1 | Channel B |
| pin_index | input | 1 | Index pulse |
| pin_home | input | 1 | Home pulse |
| pin_gate | input | 1 | External gate |
| pin_updn | input | 1 | External direction |
| count | output | 32 | Position count |
| dir_up | output | 1 | Last step direction |

## Verification
The assertions assume that software writes and configuration are driven synchronously. They also assume that the wrap bounds satisfy `load_val` <= `cmp_val`, with the count already inside that range when the wrap check applies. The stimulus changes encoder pins one channel at a time, except where a both-channel jump is deliberate. It also leaves at least four clocks between pin changes, so every edge passes the two-stage synchroniser before the next one arrives. Configuration changes are made while the pins are quiet, and the count is set by a software write before each scenario.

// File: rtl/qpos_pkg.sv
package qpos_pkg;
  typedef enum logic [1:0] {
    CM_QUAD    = 2'b00,
    CM_EXTDIR  = 2'b01,
    CM_EXTGATE = 2'b10,
    CM_TIMER   = 2'b11
  } ctl_mode_e;

  typedef enum logic [2:0] {
    IM_NONE  = 3'b000,
    IM_RESET = 3'b001,
    IM_NEXT  = 3'b010,
    IM_HOME1 = 3'b011,
    IM_HOME2 = 3'b100,
    IM_CMP   = 3'b101,
    IM_MOD   = 3'b110,
    IM_MODLD = 3'b111
  } init_mode_e;
endpackage

// File: rtl/qpos_sync.sv
module qpos_sync #(
  parameter int N      = 6,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [N-1:0] d,
  output logic [N-1:0] q
);
  logic [N-1:0] stg [STAGES];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < STAGES; i++) stg[i] <= '0;
    end else begin
      stg[0] <= d;
      for (int i = 1; i < STAGES; i++) stg[i] <= stg[i-1];
    end
  end

  assign q = stg[STAGES-1];
endmodule

// File: rtl/qpos_decode.sv
module qpos_decode (
  input  logic clk,
  input  logic rst,
  input  logic a,
  input  logic b,
  output logic step,
  output logic up
);
  logic a_q, b_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      a_q <= 1'b0;
      b_q <= 1'b0;
    end else begin
      a_q <= a;
      b_q <= b;
    end
  end

  // exactly one channel moved
  assign step = (a ^ a_q) ^ (b ^ b_q);
  // A leading B counts up
  assign up   = a ^ b_q;
endmodule

// File: rtl/qpos_prescale.sv
module qpos_prescale #(
  parameter int SEL_W = 3
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             run,
  input  logic [SEL_W-1:0] sel,
  output logic             tick
);
  localparam int DIV_W = (1 << SEL_W) - 1;

  logic [DIV_W-1:0] pc;
  logic [DIV_W-1:0] mask;

  assign mask = (DIV_W'(1) << sel) - DIV_W'(1);
  assign tick = run && ((pc & mask) == mask);

  always_ff @(posedge clk) begin
    if (rst || !run) pc <= '0;
    else             pc <= pc + DIV_W'(1);
  end
endmodule

// File: rtl/qpos_index.sv
module qpos_index
  import qpos_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       active,
  input  init_mode_e mode,
  input  logic       idx,
  input  logic       home,
  input  logic       a,
  input  logic       b,
  input  logic [1:0] match,
  input  logic       arm,
  output logic       to_zero,
  output logic       to_init,
  output logic       to_load
);
  logic       hit, hit_q, home_q, ev, home_ev, armed;
  logic [1:0] hstate;

  assign hit     = idx && ({b, a} == match);
  assign ev      = active && hit && !hit_q;
  assign home_ev = active && home && !home_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      hit_q  <= 1'b0;
      home_q <= 1'b0;
      armed  <= 1'b1;
      hstate <= 2'd0;
    end else begin
      hit_q  <= hit;
      home_q <= home;
      if (arm)                                armed <= 1'b1;
      else if (ev && mode == IM_NEXT)         armed <= 1'b0;
      if (ev && mode == IM_HOME1 && hstate != 2'd0) hstate <= 2'd0;
      else if (ev && mode == IM_HOME2 && hstate == 2'd1) hstate <= 2'd2;
      else if (ev && mode == IM_HOME2 && hstate == 2'd2) hstate <= 2'd0;
      else if (home_ev)                       hstate <= 2'd1;
    end
  end

  assign to_zero = ev && mode == IM_RESET;
  assign to_init = ev && ((mode == IM_NEXT  && armed) ||
                          (mode == IM_HOME1 && hstate != 2'd0) ||
                          (mode == IM_HOME2 && hstate == 2'd2));
  assign to_load = ev && mode == IM_MODLD;
endmodule

// File: rtl/qpos_counter.sv
module qpos_counter
  import qpos_pkg::*;
#(
  parameter int CNT_W       = 32,
  parameter int SYNC_STAGES = 2,
  parameter int PRE_SEL_W   = 3
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 enable,
  input  logic [1:0]           ctl_mode,
  input  logic [2:0]           init_mode,
  input  logic                 dir_neg,
  input  logic                 gate_en,
  input  logic                 swap_ab,
  input  logic                 invert_ab,
  input  logic [1:0]           match_ab,
  input  logic [PRE_SEL_W-1:0] prescale_sel,
  input  logic                 arm_next,
  input  logic                 cnt_wr,
  input  logic [CNT_W-1:0]     cnt_wdata,
  input  logic [CNT_W-1:0]     init_val,
  input  logic [CNT_W-1:0]     cmp_val,
  input  logic [CNT_W-1:0]     load_val,
  input  logic                 pin_a,
  input  logic                 pin_b,
  input  logic                 pin_index,
  input  logic                 pin_home,
  input  logic                 pin_gate,
  input  logic                 pin_updn,
  output logic [CNT_W-1:0]     count,
  output logic                 dir_up
);
  localparam int NSYNC = 6;

  ctl_mode_e  cm;
  init_mode_e im;
  assign cm = ctl_mode_e'(ctl_mode);
  assign im = init_mode_e'(init_mode);

  logic [NSYNC-1:0] raw, syn;
  logic a_s, b_s, idx_s, home_s, gate_s, updn_s;
  assign raw = {pin_updn, pin_gate, pin_home, pin_index, pin_b, pin_a};
  assign {updn_s, gate_s, home_s, idx_s, b_s, a_s} = syn;

  qpos_sync #(.N(NSYNC), .STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst(rst), .d(raw), .q(syn)
  );

  // conditioned channels: swap first, then polarity
  logic a_p, b_p;
  assign a_p = (swap_ab ? b_s : a_s) ^ invert_ab;
  assign b_p = (swap_ab ? a_s : b_s) ^ invert_ab;

  logic q_step, q_up;
  qpos_decode u_dec (
    .clk(clk), .rst(rst), .a(a_p), .b(b_p), .step(q_step), .up(q_up)
  );

  logic tick;
  qpos_prescale #(.SEL_W(PRE_SEL_W)) u_pre (
    .clk(clk), .rst(rst), .run(enable && cm == CM_TIMER),
    .sel(prescale_sel), .tick(tick)
  );

  logic idx_active, to_zero, to_init, to_load;
  assign idx_active = enable && !ctl_mode[1];
  qpos_index u_idx (
    .clk(clk), .rst(rst), .active(idx_active), .mode(im),
    .idx(idx_s), .home(home_s), .a(a_p), .b(b_p), .match(match_ab),
    .arm(arm_next), .to_zero(to_zero), .to_init(to_init), .to_load(to_load)
  );

  logic a_prev, a_rise;
  always_ff @(posedge clk) begin
    if (rst) a_prev <= 1'b0;
    else     a_prev <= a_s;
  end
  assign a_rise = a_s && !a_prev;

  logic stp_raw, stp, stp_up, modulo;
  always_comb begin
    unique case (cm)
      CM_QUAD:    begin stp_raw = q_step;           stp_up = q_up ^ dir_neg; end
      CM_EXTDIR:  begin stp_raw = a_rise;           stp_up = updn_s;         end
      CM_EXTGATE: begin stp_raw = a_rise && gate_s; stp_up = !dir_neg;       end
      default:    begin stp_raw = tick;             stp_up = !dir_neg;       end
    endcase
  end
  assign stp    = stp_raw && (!gate_en || gate_s);
  assign modulo = idx_active && (im == IM_MOD || im == IM_MODLD);

  always_ff @(posedge clk) begin
    if (rst) begin
      count  <= '0;
      dir_up <= 1'b1;
    end else if (cnt_wr) begin
      count <= cnt_wdata;
    end else if (enable) begin
      if (to_zero)                                     count <= '0;
      else if (to_init)                                count <= init_val;
      else if (to_load)                                count <= load_val;
      else if (idx_active && im == IM_CMP && count == cmp_val) count <= '0;
      else if (stp) begin
        dir_up <= stp_up;
        if (stp_up) count <= (modulo && count == cmp_val)  ? load_val : count + CNT_W'(1);
        else        count <= (modulo && count == load_val) ? cmp_val  : count - CNT_W'(1);
      end
    end
  end
endmodule

// File: rtl/qpos_counter_chk.sv
module qpos_counter_chk #(
  parameter int CNT_W = 32
) (
  input logic             clk,
  input logic             rst,
  input logic             enable,
  input logic [1:0]       ctl_mode,
  input logic [2:0]       init_mode,
  input logic             dir_neg,
  input logic             gate_en,
  input logic             gate_s,
  input logic             cnt_wr,
  input logic [CNT_W-1:0] cnt_wdata,
  input logic [CNT_W-1:0] cmp_val,
  input logic [CNT_W-1:0] load_val,
  input logic [CNT_W-1:0] count
);
  assert_hold_disabled_R7: assert property (@(posedge clk) disable iff (rst)
    (!enable && !cnt_wr) |=> count == $past(count));

  assert_write_load_R7: assert property (@(posedge clk) disable iff (rst)
    cnt_wr |=> count == $past(cnt_wdata));

  assert_timer_unit_step_R5: assert property (@(posedge clk) disable iff (rst)
    (enable && !cnt_wr && ctl_mode[1]) |=>
      (count == $past(count) || count == $past(count) + CNT_W'(1) ||
       count == $past(count) - CNT_W'(1)));

  assert_timer_up_dir_R3: assert property (@(posedge clk) disable iff (rst)
    (enable && !cnt_wr && ctl_mode == 2'b11 && !dir_neg) |=>
      (count == $past(count) || count == $past(count) + CNT_W'(1)));

  assert_gate_block_R6: assert property (@(posedge clk) disable iff (rst)
    (enable && !cnt_wr && gate_en && !gate_s && ctl_mode[1]) |=> $stable(count));

  assert_modulo_range_R12: assert property (@(posedge clk) disable iff (rst)
    (enable && !cnt_wr && !ctl_mode[1] && init_mode == 3'b110 &&
     load_val <= cmp_val && count >= load_val && count <= cmp_val) |=>
      (count >= $past(load_val) && count <= $past(cmp_val)));
endmodule

bind qpos_counter qpos_counter_chk #(.CNT_W(CNT_W)) u_chk (
  .clk(clk), .rst(rst), .enable(enable), .ctl_mode(ctl_mode),
  .init_mode(init_mode), .dir_neg(dir_neg), .gate_en(gate_en),
  .gate_s(gate_s), .cnt_wr(cnt_wr), .cnt_wdata(cnt_wdata),
  .cmp_val(cmp_val), .load_val(load_val), .count(count)
);

// File: tb/qpos_counter_tb.sv
module qpos_counter_tb;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  logic rst, enable, dir_neg, gate_en, swap_ab, invert_ab, arm_next, cnt_wr;
  logic [1:0] ctl_mode, match_ab;
  logic [2:0] init_mode, prescale_sel;
  logic [31:0] cnt_wdata, init_val, cmp_val, load_val, count;
  logic pin_a, pin_b, pin_index, pin_home, pin_gate, pin_updn, dir_up;

  qpos_counter u_dut (
    .clk(clk), .rst(rst), .enable(enable), .ctl_mode(ctl_mode),
    .init_mode(init_mode), .dir_neg(dir_neg), .gate_en(gate_en),
    .swap_ab(swap_ab), .invert_ab(invert_ab), .match_ab(match_ab),
    .prescale_sel(prescale_sel), .arm_next(arm_next), .cnt_wr(cnt_wr),
    .cnt_wdata(cnt_wdata), .init_val(init_val), .cmp_val(cmp_val),
    .load_val(load_val), .pin_a(pin_a), .pin_b(pin_b), .pin_index(pin_index),
    .pin_home(pin_home), .pin_gate(pin_gate), .pin_updn(pin_updn),
    .count(count), .dir_up(dir_up)
  );

  int n_chk = 0, n_fail = 0;
  int ph = 0;
  bit done = 0;

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic settle(int n = 4);
    repeat (n) @(negedge clk);
  endtask

  task automatic drive_ph();
    case (ph & 3)
      0: begin pin_a = 0; pin_b = 0; end
      1: begin pin_a = 1; pin_b = 0; end
      2: begin pin_a = 1; pin_b = 1; end
      default: begin pin_a = 0; pin_b = 1; end
    endcase
    settle();
  endtask

  task automatic q_move(bit up);
    ph = up ? ph + 1 : ph + 3;
    drive_ph();
  endtask

  task automatic q_jump();
    ph = ph + 2;
    drive_ph();
  endtask

  task automatic wr(logic [31:0] v);
    cnt_wr = 1; cnt_wdata = v;
    @(negedge clk);
    cnt_wr = 0;
  endtask

  task automatic idx_pulse();
    pin_index = 1; settle();
    pin_index = 0; settle();
  endtask

  task automatic home_pulse();
    pin_home = 1; settle();
    pin_home = 0; settle();
  endtask

  task automatic a_pulse();
    pin_a = 1; settle();
    pin_a = 0; settle();
  endtask

  task automatic t_reset();
    chk("R1 count", count, 0);
    chk("R1 dir_up", {31'd0, dir_up}, 1);
  endtask

  task automatic t_quad();
    enable = 1; ctl_mode = 2'b00; init_mode = 3'b000;
    wr(100);
    q_move(1); q_move(1); q_move(1); q_move(1);
    chk("R2 four up edges", count, 104);
    chk("R14 up", {31'd0, dir_up}, 1);
    q_move(0); q_move(0); q_move(0);
    chk("R2 three down edges", count, 101);
    chk("R14 down", {31'd0, dir_up}, 0);
    q_jump();
    chk("R2 both-change ignored", count, 101);
    q_move(1);
    chk("R2 after jump", count, 102);
    dir_neg = 1; q_move(1); dir_neg = 0;
    chk("R3 dir_neg quad", count, 101);
    while ((ph & 3) != 0) q_move(1);
  endtask

  task automatic t_updn();
    ctl_mode = 2'b01; wr(50);
    pin_updn = 1; dir_neg = 1; settle();
    a_pulse(); a_pulse();
    chk("R3 updn up", count, 52);
    pin_updn = 0; settle();
    a_pulse();
    chk("R3 updn down", count, 51);
    dir_neg = 0;
  endtask

  task automatic t_gated();
    ctl_mode = 2'b10; init_mode = 3'b001; match_ab = 2'b00; wr(20);
    pin_gate = 1; settle();
    a_pulse();
    chk("R4 gated count", count, 21);
    idx_pulse();
    chk("R4 index ignored", count, 21);
    pin_gate = 0; settle();
    a_pulse();
    chk("R4 gate low", count, 21);
    init_mode = 3'b000; ctl_mode = 2'b00;
  endtask

  task automatic t_index();
    init_mode = 3'b001; match_ab = 2'b00; wr(77);
    idx_pulse();
    chk("R8 index reset", count, 0);
    match_ab = 2'b11; wr(77);
    idx_pulse();
    chk("R8 mismatch", count, 77);
    invert_ab = 1; settle();
    chk("R8 invert no step", count, 77);
    idx_pulse();
    chk("R8 inverted match", count, 0);
    invert_ab = 0; settle();
    q_move(1);
    swap_ab = 1; settle();
    wr(77); match_ab = 2'b10;
    idx_pulse();
    chk("R8 swapped match", count, 0);
    swap_ab = 0; settle();
    q_move(0);
    match_ab = 2'b00;
  endtask

  task automatic t_next();
    init_mode = 3'b010; wr(5);
    idx_pulse();
    chk("R9 first load", count, 1000);
    wr(5); idx_pulse();
    chk("R9 disarmed", count, 5);
    arm_next = 1; @(negedge clk); arm_next = 0;
    idx_pulse();
    chk("R9 rearmed", count, 1000);
  endtask

  task automatic t_home();
    init_mode = 3'b011; wr(5);
    idx_pulse();
    chk("R10 no home", count, 5);
    home_pulse(); idx_pulse();
    chk("R10 first after home", count, 1000);
    wr(5); idx_pulse();
    chk("R10 home consumed", count, 5);
    init_mode = 3'b100;
    home_pulse(); idx_pulse();
    chk("R10 second: one seen", count, 5);
    idx_pulse();
    chk("R10 second index", count, 1000);
  endtask

  task automatic t_cmp();
    init_mode = 3'b101; cmp_val = 10; wr(8);
    q_move(1);
    chk("R11 below", count, 9);
    q_move(1);
    chk("R11 reset at compare", count, 0);
    cmp_val = 6;
    while ((ph & 3) != 0) q_move(1);
  endtask

  task automatic t_mod();
    init_mode = 3'b110; wr(6);
    q_move(1);
    chk("R12 wrap up", count, 3);
    q_move(0);
    chk("R12 wrap down", count, 6);
    q_move(0);
    chk("R12 plain down", count, 5);
    while ((ph & 3) != 0) q_move(1);
    init_mode = 3'b111; wr(5);
    idx_pulse();
    chk("R13 index reload", count, 3);
    wr(6); q_move(1);
    chk("R12 wrap in 111", count, 3);
    init_mode = 3'b000;
  endtask

  task automatic t_timer();
    enable = 0; ctl_mode = 2'b11; prescale_sel = 3'd2;
    wr(42);
    chk("R7 write while disabled", count, 42);
    wr(0);
    enable = 1; settle(16); enable = 0;
    chk("R5 divide by 4", count, 4);
    settle(8);
    chk("R7 hold disabled", count, 4);
    dir_neg = 1; enable = 1; settle(8); enable = 0; dir_neg = 0;
    chk("R3 timer down", count, 2);
    gate_en = 1; pin_gate = 0; settle();
    enable = 1; settle(16); enable = 0;
    chk("R6 gate blocks", count, 2);
    gate_en = 0;
  endtask

  initial begin
    rst = 1; enable = 0; ctl_mode = 0; init_mode = 0; dir_neg = 0;
    gate_en = 0; swap_ab = 0; invert_ab = 0; match_ab = 0;
    prescale_sel = 0; arm_next = 0; cnt_wr = 0; cnt_wdata = 0;
    init_val = 1000; cmp_val = 6; load_val = 3;
    pin_a = 0; pin_b = 0; pin_index = 0; pin_home = 0; pin_gate = 0; pin_updn = 0;
    settle(3);
    rst = 0;
    @(negedge clk);
    t_reset();
    t_quad();
    t_updn();
    t_gated();
    t_index();
    t_next();
    t_home();
    t_cmp();
    t_mod();
    t_timer();
    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end
endmodule